// File: doc/BRIEF.md
# Train door panel sequencer

This block turns open and close requests for one passenger door into the three panel actuator lines (enable, direction, speed). It reads five position sensors, and it sounds a warning chime before every closing movement. The closing motion starts only after the chime has run for a fixed number of millisecond ticks, which is 1 s at the default setting. Opening is commanded as fast movement and closing as slow movement. Both movements hold enable and direction high, so the speed line alone tells the two apart.

The controller has four states: idle, opening, chime and closing. A close request aborts an opening in progress. An open request cancels a pending close during the chime and reverses a closing movement. When both requests are present in the same cycle, the close request wins. A movement stops when its end sensor reports: fully open for opening, closed-and-locked for closing. A status output repeats the fully-open sensor for the rest of the train logic. Sensor debouncing and motor drive are handled outside this block.

Top module: `door_panel_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, pnl_enable, pnl_dir, pnl_fast and chime are all 0 and the block is idle.
- R2: From idle, with req_open=1, req_close=0 and sns_open=0, the next cycle shows the opening command pnl_enable=1, pnl_dir=1, pnl_fast=1. This command holds while opening continues.
- R3: A close request from idle (when not locked) or during opening gives chime=1 with pnl_enable=0 on the next cycle.
- R4: The chime phase lasts until DELAY_TICKS (default 1000) tick_ms pulses have been seen while chiming. The cycle after the last of these pulses shows the closing command pnl_enable=1, pnl_dir=1, pnl_fast=0, with chime=0.
- R5: A close request during the chime phase restarts the tick count from zero, and that cycle's tick does not count.
- R6: An open request without a close request during the chime phase cancels the close and starts opening on the next cycle. If both requests are present, the chime restarts.
- R7: During opening, with sns_open=1 and no close request, all commands are 0 on the next cycle.
- R8: During closing, with sns_locked=1 and no open request, all commands are 0 on the next cycle. An open request without a close request during closing reverses to opening on the next cycle.
- R9: open_done equals sns_open in the same cycle.
- R10: In idle, a close request is ignored while sns_locked=1, and an open request is ignored while sns_open=1.
- R11: A close request during closing is ignored. The closing command continues and no new chime starts.
- R12: sns_closed, sns_near_closed and sns_near_open have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_open | input | 1 | Open request |
| req_close | input | 1 | Close request |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| sns_closed | input | 1 | Panels fully closed |
| sns_open | input | 1 | Panels fully open |
| sns_near_closed | input | 1 | Panels approaching closed |
| sns_near_open | input | 1 | Panels approaching open |
| sns_locked | input | 1 | Panels closed and locked |
| pnl_enable | output | 1 | Panel movement enable |
| pnl_dir | output | 1 | Panel direction command |
| pnl_fast | output | 1 | Panel speed command, 1 = fast |
| chime | output | 1 | Warning chime active |
| open_done | output | 1 | Door fully open status |

## Verification
Each of the four states has its own pattern on the three command lines and the chime. A wrong state register therefore shows at the ports in the cycle right after the transition that went wrong. A tick counter that is off by even one pulse moves the start of slow closing by one tick period. This is caught at the exact end of a full chime, and also after a restart that follows a partly counted chime. A wrong priority between the requests, the end sensors and the chime timeout appears as the wrong command one cycle after the two conflicting events arrive together.

// File: rtl/door_seq_pkg.sv
package door_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_OPENING = 2'd1,
        ST_CHIME   = 2'd2,
        ST_CLOSING = 2'd3
    } door_state_e;

    typedef struct packed {
        door_state_e state;
    } door_regs_t;

endpackage

// File: rtl/chime_timer.sv
module chime_timer #(
    parameter int DELAY_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int CNT_W = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        done_o = 1'b0;
        if (!run_i || restart_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            if (cnt_q == LAST) begin
                cnt_d  = '0;
                done_o = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
    import door_seq_pkg::*;
(
    input  door_state_e state_i,
    output logic        enable_o,
    output logic        dir_o,
    output logic        fast_o,
    output logic        chime_o
);
    always_comb begin
        enable_o = 1'b0;
        dir_o    = 1'b0;
        fast_o   = 1'b0;
        chime_o  = 1'b0;
        unique case (state_i)
            ST_OPENING: begin
                enable_o = 1'b1;
                dir_o    = 1'b1;
                fast_o   = 1'b1;
            end
            ST_CLOSING: begin
                enable_o = 1'b1;
                dir_o    = 1'b1;
            end
            ST_CHIME: chime_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/door_panel_seq.sv
module door_panel_seq
    import door_seq_pkg::*;
#(
    parameter int DELAY_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_open,
    input  logic req_close,
    input  logic tick_ms,
    input  logic sns_closed,
    input  logic sns_open,
    input  logic sns_near_closed,
    input  logic sns_near_open,
    input  logic sns_locked,
    output logic pnl_enable,
    output logic pnl_dir,
    output logic pnl_fast,
    output logic chime,
    output logic open_done
);
    door_regs_t r_d, r_q;
    logic       in_chime;
    logic       chime_done;
    logic       open_only;
    logic       unused_sns;

    assign unused_sns = sns_closed ^ sns_near_closed ^ sns_near_open;
    assign in_chime   = (r_q.state == ST_CHIME);
    assign open_only  = req_open && !req_close;

    chime_timer #(.DELAY_TICKS(DELAY_TICKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (in_chime),
        .restart_i(req_close),
        .tick_i   (tick_ms),
        .done_o   (chime_done)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_close) begin
                    if (!sns_locked) r_d.state = ST_CHIME;
                end else if (req_open && !sns_open) begin
                    r_d.state = ST_OPENING;
                end
            end
            ST_OPENING: begin
                if (req_close)     r_d.state = ST_CHIME;
                else if (sns_open) r_d.state = ST_IDLE;
            end
            ST_CHIME: begin
                if (open_only)       r_d.state = ST_OPENING;
                else if (chime_done) r_d.state = ST_CLOSING;
            end
            ST_CLOSING: begin
                if (open_only)       r_d.state = ST_OPENING;
                else if (sns_locked) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE};
        else        r_q <= r_d;
    end

    cmd_decode u_dec (
        .state_i (r_q.state),
        .enable_o(pnl_enable),
        .dir_o   (pnl_dir),
        .fast_o  (pnl_fast),
        .chime_o (chime)
    );

    assign open_done = sns_open;
endmodule

// File: rtl/door_panel_seq_chk.sv
module door_panel_seq_chk #(
    parameter int DELAY_TICKS = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic req_open,
    input logic req_close,
    input logic tick_ms,
    input logic sns_open,
    input logic sns_locked,
    input logic pnl_enable,
    input logic pnl_fast,
    input logic chime
);
    int unsigned seen_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  seen_ticks <= 0;
        else if (!chime || req_close) seen_ticks <= 0;
        else if (tick_ms)            seen_ticks <= seen_ticks + 1;
    end

    a_r1_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!pnl_enable && !chime));

    a_r3_close_aborts_open: assert property (@(posedge clk) disable iff (!rst_n)
        (req_close && pnl_enable && pnl_fast) |=> (chime && !pnl_enable));

    a_r6_open_cancels_chime: assert property (@(posedge clk) disable iff (!rst_n)
        (chime && req_open && !req_close) |=> (pnl_enable && pnl_fast));

    a_r7_stop_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        (pnl_enable && pnl_fast && sns_open && !req_close) |=> (!pnl_enable && !chime));

    a_r8_stop_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (pnl_enable && !pnl_fast && sns_locked && !req_open) |=> (!pnl_enable && !chime));

    a_r11_close_ignored_closing: assert property (@(posedge clk) disable iff (!rst_n)
        (pnl_enable && !pnl_fast && req_close && !sns_locked) |=> (pnl_enable && !pnl_fast));

    a_r4_chime_not_overlong: assert property (@(posedge clk) disable iff (!rst_n)
        chime |-> (seen_ticks < DELAY_TICKS));

    a_r4_close_after_full_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (pnl_enable && !pnl_fast && $past(chime)) |->
            ($past(tick_ms) && $past(seen_ticks) == DELAY_TICKS - 1));
endmodule

bind door_panel_seq door_panel_seq_chk #(.DELAY_TICKS(DELAY_TICKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_open  (req_open),
    .req_close (req_close),
    .tick_ms   (tick_ms),
    .sns_open  (sns_open),
    .sns_locked(sns_locked),
    .pnl_enable(pnl_enable),
    .pnl_fast  (pnl_fast),
    .chime     (chime)
);

// File: tb/tb_door_panel_seq.sv
module tb_door_panel_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DELAY      = 1000;
    localparam int M_IDLE = 0, M_OPEN = 1, M_CHIME = 2, M_CLOSE = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_open = 0, req_close = 0, tick_ms = 0;
    logic sns_closed = 0, sns_open = 0, sns_near_closed = 0, sns_near_open = 0, sns_locked = 0;
    logic pnl_enable, pnl_dir, pnl_fast, chime, open_done;

    int checks = 0;
    int errors = 0;
    int m_state = M_IDLE;
    int m_cnt = 0;
    string m_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    door_panel_seq #(.DELAY_TICKS(DELAY)) dut (
        .clk(clk), .rst_n(rst_n), .req_open(req_open), .req_close(req_close),
        .tick_ms(tick_ms), .sns_closed(sns_closed), .sns_open(sns_open),
        .sns_near_closed(sns_near_closed), .sns_near_open(sns_near_open),
        .sns_locked(sns_locked), .pnl_enable(pnl_enable), .pnl_dir(pnl_dir),
        .pnl_fast(pnl_fast), .chime(chime), .open_done(open_done)
    );

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        logic e_en, e_fast, e_ch;
        e_en   = (m_state == M_OPEN) || (m_state == M_CLOSE);
        e_fast = (m_state == M_OPEN);
        e_ch   = (m_state == M_CHIME);
        check(pnl_enable, e_en, m_tag, "pnl_enable");
        check(pnl_dir, e_en, m_tag, "pnl_dir");
        check(pnl_fast, e_fast, m_tag, "pnl_fast");
        check(chime, e_ch, m_tag, "chime");
        check(open_done, sns_open, "R9", "open_done");
    endtask

    // Reference model of the requirements, stepped once per clock edge.
    task automatic model_step();
        bit ro, rc, only_open;
        ro = req_open; rc = req_close; only_open = ro && !rc;
        case (m_state)
            M_IDLE: begin
                if (rc && !sns_locked)      begin m_state = M_CHIME; m_cnt = 0; m_tag = "R3"; end
                else if (rc)                m_tag = "R10";
                else if (ro && !sns_open)   begin m_state = M_OPEN; m_tag = "R2"; end
                else if (ro)                m_tag = "R10";
                else                        m_tag = "R12";
            end
            M_OPEN: begin
                if (rc)            begin m_state = M_CHIME; m_cnt = 0; m_tag = "R3"; end
                else if (sns_open) begin m_state = M_IDLE; m_tag = "R7"; end
                else               m_tag = "R2";
            end
            M_CHIME: begin
                if (rc)             begin m_cnt = 0; m_tag = "R5"; end
                else if (only_open) begin m_state = M_OPEN; m_tag = "R6"; end
                else if (tick_ms) begin
                    if (m_cnt == DELAY - 1) begin m_state = M_CLOSE; m_cnt = 0; end
                    else m_cnt++;
                    m_tag = "R4";
                end else m_tag = "R4";
            end
            default: begin
                if (only_open)       begin m_state = M_OPEN; m_tag = "R8"; end
                else if (sns_locked) begin m_state = M_IDLE; m_tag = "R8"; end
                else if (rc)         m_tag = "R11";
                else                 m_tag = "R4";
            end
        endcase
    endtask

    task automatic cycle(input bit ro, input bit rc, input bit tk, input bit so, input bit sl);
        @(negedge clk);
        req_open = ro; req_close = rc; tick_ms = tk; sns_open = so; sns_locked = sl;
        sns_closed = 1'($urandom_range(0, 1));
        sns_near_closed = 1'($urandom_range(0, 1));
        sns_near_open = 1'($urandom_range(0, 1));
        #1;
        check_outputs();
        @(posedge clk);
        model_step();
    endtask

    task automatic run(input int n, input bit ro, input bit rc, input bit tk, input bit so, input bit sl);
        for (int i = 0; i < n; i++) cycle(ro, rc, tk, so, sl);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int seed_dummy;
        seed_dummy = $urandom(32'h00C0_FFEE);
        // R1: reset state, with requests already present
        req_open = 1; req_close = 1; tick_ms = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check(pnl_enable, 1'b0, "R1", "pnl_enable in reset");
        check(pnl_fast, 1'b0, "R1", "pnl_fast in reset");
        check(chime, 1'b0, "R1", "chime in reset");
        req_open = 0; req_close = 0; tick_ms = 0;
        rst_n = 1'b1;
        m_state = M_IDLE; m_tag = "R1";

        // R2 / R7: open, move, stop on fully open
        run(1, 1, 0, 0, 0, 0);
        run(4, 0, 0, 1, 0, 0);
        run(2, 0, 0, 0, 1, 0);
        // R10: already open ignores open; locked ignores close
        run(2, 1, 0, 0, 1, 0);
        run(2, 0, 1, 0, 0, 1);
        // R4 / R5: close, partial chime, restart, full chime, closing
        run(1, 0, 1, 0, 0, 0);
        run(500, 0, 0, 1, 0, 0);
        run(1, 0, 1, 1, 0, 0);
        run(999, 0, 0, 1, 0, 0);
        run(3, 0, 0, 0, 0, 0);
        run(1, 0, 0, 1, 0, 0);
        run(3, 0, 0, 1, 0, 0);
        // R11: close during closing ignored; R8: stop on locked
        run(2, 0, 1, 1, 0, 0);
        run(2, 0, 0, 0, 0, 1);
        // R6: open cancels chime; both requests restart
        run(1, 0, 1, 0, 0, 0);
        run(10, 0, 0, 1, 0, 0);
        run(1, 1, 1, 1, 0, 0);
        run(1, 1, 0, 0, 0, 0);
        // R3: close aborts opening; then R8 reversal during closing
        run(1, 0, 1, 0, 0, 0);
        run(DELAY, 0, 0, 1, 0, 0);
        run(2, 0, 0, 0, 0, 0);
        run(1, 1, 0, 0, 0, 1);
        run(2, 0, 0, 0, 1, 0);

        // constrained random phase
        for (int i = 0; i < 40000; i++) begin
            bit ro, rc, tk, so, sl;
            ro = ($urandom_range(0, 2999) == 0);
            rc = ($urandom_range(0, 1999) == 0);
            tk = 1'($urandom_range(0, 1));
            so = ($urandom_range(0, 9) == 0);
            sl = ($urandom_range(0, 49) == 0);
            cycle(ro, rc, tk, so, sl);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule